// File: doc/BRIEF.md
# Camera Frame Capture Controller

This block takes the parallel output of an image sensor (frame sync, line valid and an 8-bit pixel bus, all sampled on the pixel clock) and stores one frame of bytes into a write-side buffer. The buffer memory sits outside the block. The block drives its write strobe, address and data, and it keeps the write pointer.

A host programs a mode register and issues commands through a control register. The command bits act only when written as 1 and then clear themselves. A start command arms a capture. Capture begins at the next inactive-to-active transition of the frame sync. Bytes are written on every cycle in which the line-valid signal is active. The following frame sync transition ends the capture and raises a done flag.

The host can choose the active level of each sync signal and can add one clock of delay on the pixel bus. A byte counter reports how many bytes the current capture has written.

Top module: `cam_frame_capture`

## Requirements
- R1: After reset, the mode register reads 0, the done flag is 0, the byte count is 0, the write address is 0, the buffer is not full and no write is issued.
- R2: A host write with `reg_sel_i`=0 loads all 8 bits into the mode register, and `mode_o` reads them back. Bit 0 sets the line-valid polarity, bit 1 sets the frame-sync polarity, bit 3 sets the pixel delay, bit 4 enables the buffer and bit 6 selects low power.
- R3: A host write with `reg_sel_i`=1 and bit 1 set starts a capture only while mode bit 4 is 1. Otherwise the start is ignored. A start that is accepted arms the block, and capture begins after the next inactive-to-active frame-sync transition. Lines seen while armed are not written.
- R4: During a capture, `fifo_we_o` is high one clock after each sampled cycle of active line-valid. Each write uses the current pointer as `fifo_addr_o`, and the pointer then advances by one.
- R5: Polarity bit value 0 means the signal is active high. Value 1 means it is active low.
- R6: With mode bit 3 at 0, the written byte is the pixel sampled in the same cycle as the line-valid sample that caused the write. With bit 3 at 1, it is the pixel sampled one clock earlier.
- R7: The next inactive-to-active frame-sync transition during a capture ends it and sets `done_o`. No write is issued in that cycle. A control write with bit 0 set clears `done_o`, and an accepted start also clears it.
- R8: A control write with bit 4 set returns the write pointer to 0. Otherwise the pointer keeps its value from one capture to the next.
- R9: When the pointer equals DEPTH, `fifo_full_o` is high and no write is issued. The frame still ends with `done_o` set.
- R10: While mode bit 6 is 1, no byte is written. The capture still ends with `done_o` set.
- R11: `byte_cnt_o` is cleared by an accepted start and increments once for each write issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 1 | 0 selects the mode register, 1 selects the control register |
| reg_wdata_i | input | 8 | Host write data |
| vsync_i | input | 1 | Sensor frame sync |
| href_i | input | 1 | Sensor line valid |
| pix_i | input | DATA_W | Sensor pixel bus |
| mode_o | output | 8 | Mode register value |
| done_o | output | 1 | Frame write done flag |
| byte_cnt_o | output | PTR_W | Bytes written by the current capture |
| fifo_we_o | output | 1 | Buffer write strobe |
| fifo_addr_o | output | ADDR_W | Buffer write address |
| fifo_wdata_o | output | DATA_W | Buffer write data |
| fifo_full_o | output | 1 | Write pointer has reached DEPTH |

## Verification
Frames are sent with both polarity settings. This tells inverted sync decoding apart from a capture that never starts or that writes during blanking. A line sent while the block is only armed, and a start sent with the buffer disabled, show whether arming waits for the frame transition and whether the enable gate is honoured. Frames with the pixel delay on and with low power on separate the two data paths and the write gate. A frame longer than the space left in the buffer exercises the stop at full together with normal frame completion.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  localparam int MODE_HREF_POL  = 0;
  localparam int MODE_VSYNC_POL = 1;
  localparam int MODE_DELAY     = 3;
  localparam int MODE_BUF_EN    = 4;
  localparam int MODE_LOW_PWR   = 6;

  localparam int CTL_CLR_DONE = 0;
  localparam int CTL_START    = 1;
  localparam int CTL_PTR_RST  = 4;

  typedef enum logic [1:0] {
    CS_IDLE    = 2'd0,
    CS_ARMED   = 2'd1,
    CS_CAPTURE = 2'd2
  } cap_state_e;

  typedef struct packed {
    logic clr_done;
    logic start;
    logic ptr_rst;
  } ctl_pulse_t;
endpackage

// File: rtl/cam_host_regs.sv
module cam_host_regs
  import cam_cap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] mode_o,
  output ctl_pulse_t pulse_o
);
  logic [7:0] mode_q;
  logic       ctl_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    mode_q <= '0;
    else if (reg_we_i && !reg_sel_i) mode_q <= reg_wdata_i;
  end

  // command bits exist only for the cycle of the write
  assign ctl_wr           = reg_we_i && reg_sel_i;
  assign pulse_o.clr_done = ctl_wr && reg_wdata_i[CTL_CLR_DONE];
  assign pulse_o.start    = ctl_wr && reg_wdata_i[CTL_START] && mode_q[MODE_BUF_EN];
  assign pulse_o.ptr_rst  = ctl_wr && reg_wdata_i[CTL_PTR_RST];
  assign mode_o           = mode_q;
endmodule

// File: rtl/cam_sync_norm.sv
module cam_sync_norm #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              href_i,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              vs_pol_i,
  input  logic              hr_pol_i,
  input  logic              dly_i,
  output logic              frame_edge_o,
  output logic              line_act_o,
  output logic [DATA_W-1:0] pix_o
);
  logic              vs_q, vs_prev_q, hr_q;
  logic [DATA_W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q      <= 1'b0;
      vs_prev_q <= 1'b0;
      hr_q      <= 1'b0;
    end else begin
      vs_q      <= vsync_i ^ vs_pol_i;
      vs_prev_q <= vs_q;
      hr_q      <= href_i ^ hr_pol_i;
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= pix_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign frame_edge_o = vs_q && !vs_prev_q;
  assign line_act_o   = hr_q;
  assign pix_o        = dly_i ? pipe_q[STAGES-1] : pipe_q[0];
endmodule

// File: rtl/cam_cap_fsm.sv
module cam_cap_fsm
  import cam_cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clr_done_i,
  input  logic frame_edge_i,
  input  logic line_act_i,
  input  logic low_pwr_i,
  input  logic full_i,
  output logic capturing_o,
  output logic wr_o,
  output logic done_o
);
  cap_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    if (start_i) state_d = CS_ARMED;
    else begin
      unique case (state_q)
        CS_ARMED:   if (frame_edge_i) state_d = CS_CAPTURE;
        CS_CAPTURE: if (frame_edge_i) state_d = CS_IDLE;
        default:    state_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i || clr_done_i)                        done_q <= 1'b0;
      else if (state_q == CS_CAPTURE && frame_edge_i)  done_q <= 1'b1;
    end
  end

  assign capturing_o = (state_q == CS_CAPTURE);
  // the closing frame edge writes nothing
  assign wr_o   = capturing_o && line_act_i && !low_pwr_i && !full_i && !frame_edge_i;
  assign done_o = done_q;
endmodule

// File: rtl/cam_wr_ptr.sv
module cam_wr_ptr #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_rst_i,
  input  logic              start_i,
  input  logic              wr_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [PTR_W-1:0]  cnt_o,
  output logic              full_o
);
  logic [PTR_W-1:0] ptr_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ptr_rst_i) ptr_q <= '0;
      else if (wr_i) ptr_q <= ptr_q + 1'b1;
      if (start_i)   cnt_q <= '0;
      else if (wr_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign cnt_o  = cnt_q;
  assign full_o = (ptr_q == PTR_W'(DEPTH));
endmodule

// File: rtl/cam_frame_capture.sv
module cam_frame_capture
  import cam_cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              vsync_i,
  input  logic              href_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic [7:0]        mode_o,
  output logic              done_o,
  output logic [PTR_W-1:0]  byte_cnt_o,
  output logic              fifo_we_o,
  output logic [ADDR_W-1:0] fifo_addr_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              fifo_full_o
);
  ctl_pulse_t       pulse;
  logic             start_acc, ptr_rst, capturing;
  logic             frame_edge, line_act, wr_en;
  logic [PTR_W-1:0] wr_ptr;

  cam_host_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .mode_o (mode_o),
    .pulse_o(pulse)
  );

  assign start_acc = pulse.start;
  assign ptr_rst   = pulse.ptr_rst;

  cam_sync_norm #(.DATA_W(DATA_W), .STAGES(2)) u_norm (
    .clk_i, .rst_ni, .vsync_i, .href_i, .pix_i,
    .vs_pol_i    (mode_o[MODE_VSYNC_POL]),
    .hr_pol_i    (mode_o[MODE_HREF_POL]),
    .dly_i       (mode_o[MODE_DELAY]),
    .frame_edge_o(frame_edge),
    .line_act_o  (line_act),
    .pix_o       (fifo_wdata_o)
  );

  cam_cap_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i     (start_acc),
    .clr_done_i  (pulse.clr_done),
    .frame_edge_i(frame_edge),
    .line_act_i  (line_act),
    .low_pwr_i   (mode_o[MODE_LOW_PWR]),
    .full_i      (fifo_full_o),
    .capturing_o (capturing),
    .wr_o        (wr_en),
    .done_o      (done_o)
  );

  cam_wr_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni,
    .ptr_rst_i(ptr_rst),
    .start_i  (start_acc),
    .wr_i     (wr_en),
    .ptr_o    (wr_ptr),
    .cnt_o    (byte_cnt_o),
    .full_o   (fifo_full_o)
  );

  assign fifo_we_o   = wr_en;
  assign fifo_addr_o = wr_ptr[ADDR_W-1:0];
endmodule

// File: rtl/cam_frame_capture_chk.sv
module cam_frame_capture_chk #(
  parameter int PTR_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_we_o,
  input logic             fifo_full_o,
  input logic             done_o,
  input logic [7:0]       mode_o,
  input logic [PTR_W-1:0] byte_cnt_o,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             capturing,
  input logic             ptr_rst,
  input logic             start_acc
);
  a_r4_write_in_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> capturing);

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o && !ptr_rst |=> wr_ptr == PTR_W'($past(wr_ptr) + 1'b1));

  a_r11_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o && !start_acc |=> byte_cnt_o == PTR_W'($past(byte_cnt_o) + 1'b1));

  a_r9_no_write_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> !fifo_we_o);

  a_r10_low_power_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[6] |-> !fifo_we_o);

  a_r7_done_from_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(capturing));

  a_r3_armed_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> !fifo_we_o);

  a_r8_ptr_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst |=> wr_ptr == '0);
endmodule

bind cam_frame_capture cam_frame_capture_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_we_o  (fifo_we_o),
  .fifo_full_o(fifo_full_o),
  .done_o     (done_o),
  .mode_o     (mode_o),
  .byte_cnt_o (byte_cnt_o),
  .wr_ptr     (wr_ptr),
  .capturing  (capturing),
  .ptr_rst    (ptr_rst),
  .start_acc  (start_acc)
);

// File: tb/cam_frame_capture_tb_top.sv
`timescale 1ns/1ps
module cam_frame_capture_tb_top;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic              reg_sel_i = 1'b0;
  logic [7:0]        reg_wdata_i = '0;
  logic              vsync_i = 1'b0;
  logic              href_i = 1'b0;
  logic [7:0]        pix_i = '0;
  logic [7:0]        mode_o;
  logic              done_o;
  logic [PTR_W-1:0]  byte_cnt_o;
  logic              fifo_we_o;
  logic [ADDR_W-1:0] fifo_addr_o;
  logic [7:0]        fifo_wdata_o;
  logic              fifo_full_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  cam_frame_capture #(.DATA_W(8), .DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .vsync_i, .href_i, .pix_i,
    .mode_o, .done_o, .byte_cnt_o, .fifo_we_o, .fifo_addr_o,
    .fifo_wdata_o, .fifo_full_o
  );

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: state 0 idle, 1 armed, 2 capturing
  logic [7:0] m_mode;
  int         m_state, m_ptr, m_cnt;
  bit         m_done, m_vs, m_vs_prev, m_hr;
  logic [7:0] m_d0, m_d1;

  function automatic bit m_edge();
    return m_vs && !m_vs_prev;
  endfunction

  function automatic bit m_we();
    return m_state == 2 && m_hr && !m_mode[6] && m_ptr != DEPTH && !m_edge();
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_state = 0; m_ptr = 0; m_cnt = 0; m_done = 0;
      m_vs = 0; m_vs_prev = 0; m_hr = 0; m_d0 = 0; m_d1 = 0;
    end else begin
      bit [7:0] ctl;
      bit we, edg, start;
      ctl   = (reg_we_i && reg_sel_i) ? reg_wdata_i : 8'h00;
      we    = m_we();
      edg   = m_edge();
      start = ctl[1] && m_mode[4];
      if (ctl[4]) m_ptr = 0; else if (we) m_ptr++;
      if (start) m_cnt = 0; else if (we) m_cnt++;
      if (start || ctl[0]) m_done = 0;
      else if (m_state == 2 && edg) m_done = 1;
      if (start) m_state = 1;
      else if (edg && m_state == 1) m_state = 2;
      else if (edg && m_state == 2) m_state = 0;
      m_vs_prev = m_vs;
      m_vs = vsync_i ^ m_mode[1];
      m_hr = href_i ^ m_mode[0];
      m_d1 = m_d0;
      m_d0 = pix_i;
      if (reg_we_i && !reg_sel_i) m_mode = reg_wdata_i;
    end
  end

  // per-cycle comparison; outputs depend only on registers
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk("R4", "fifo_we", int'(fifo_we_o), int'(m_we()));
      chk("R4", "fifo_addr", int'(fifo_addr_o), m_ptr % DEPTH);
      if (m_we()) chk("R6", "fifo_wdata", int'(fifo_wdata_o),
                      int'(m_mode[3] ? m_d1 : m_d0));
      chk("R7", "done", int'(done_o), int'(m_done));
      chk("R11", "byte_cnt", int'(byte_cnt_o), m_cnt);
      chk("R9", "full", int'(fifo_full_o), int'(m_ptr == DEPTH));
      chk("R2", "mode", int'(mode_o), int'(m_mode));
    end
  end

  always @(negedge clk_i) pix_i <= pix_i + 8'd37;

  task automatic host_wr(bit sel, logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic set_mode(logic [7:0] m);
    host_wr(1'b0, m);
    vsync_i = m[1];
    href_i  = m[0];
    repeat (3) @(negedge clk_i);
  endtask

  task automatic vs_pulse(bit vpol);
    @(negedge clk_i);
    vsync_i = ~vpol;
    repeat (2) @(negedge clk_i);
    vsync_i = vpol;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic line(bit hpol, int n);
    @(negedge clk_i);
    href_i = ~hpol;
    repeat (n) @(negedge clk_i);
    href_i = hpol;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic frame(int lines, int len, bit vpol, bit hpol);
    vs_pulse(vpol);
    for (int i = 0; i < lines; i++) line(hpol, len);
    vs_pulse(vpol);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "mode", int'(mode_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "count", int'(byte_cnt_o), 0);
    chk("R1", "addr", int'(fifo_addr_o), 0);
    chk("R1", "we", int'(fifo_we_o), 0);
    chk("R1", "full", int'(fifo_full_o), 0);

    // R3 start ignored with buffer disabled
    host_wr(1'b1, 8'h02);
    frame(2, 4, 1'b0, 1'b0);
    chk("R3", "count disabled", int'(byte_cnt_o), 0);
    chk("R3", "done disabled", int'(done_o), 0);

    // R3/R7/R11 normal capture, a line while armed is skipped
    set_mode(8'h10);
    chk("R2", "mode readback", int'(mode_o), 8'h10);
    host_wr(1'b1, 8'h02);
    line(1'b0, 3);
    chk("R3", "armed no write", int'(byte_cnt_o), 0);
    frame(2, 5, 1'b0, 1'b0);
    chk("R7", "done set", int'(done_o), 1);
    chk("R11", "count frame", int'(byte_cnt_o), 10);
    host_wr(1'b1, 8'h01);
    @(negedge clk_i);
    chk("R7", "done cleared", int'(done_o), 0);

    // R8 pointer reset, R5 active-low syncs
    host_wr(1'b1, 8'h10);
    @(negedge clk_i);
    chk("R8", "ptr reset", int'(fifo_addr_o), 0);
    set_mode(8'h13);
    host_wr(1'b1, 8'h02);
    frame(3, 4, 1'b1, 1'b1);
    chk("R5", "count inverted", int'(byte_cnt_o), 12);
    chk("R5", "done inverted", int'(done_o), 1);

    // R6 delayed data, R8 pointer carries over
    set_mode(8'h18);
    host_wr(1'b1, 8'h02);
    chk("R7", "start clears done", int'(done_o), 0);
    frame(2, 6, 1'b0, 1'b0);
    chk("R6", "count delayed", int'(byte_cnt_o), 12);
    chk("R8", "ptr held", int'(fifo_addr_o), 24);

    // R10 low power
    set_mode(8'h50);
    host_wr(1'b1, 8'h02);
    frame(2, 5, 1'b0, 1'b0);
    chk("R10", "count low power", int'(byte_cnt_o), 0);
    chk("R10", "done low power", int'(done_o), 1);
    chk("R10", "ptr unchanged", int'(fifo_addr_o), 24);

    // R9 frame overruns buffer space
    set_mode(8'h10);
    host_wr(1'b1, 8'h02);
    frame(8, 10, 1'b0, 1'b0);
    chk("R9", "full", int'(fifo_full_o), 1);
    chk("R9", "count to full", int'(byte_cnt_o), 40);
    chk("R9", "done at full", int'(done_o), 1);

    repeat (4) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end
endmodule